// File: doc/BRIEF.md
# Dual-Rail Balanced Bitwise ALU

This unit is a small execution-unit extension for a processor that runs sensitive code in a hiding style. A balanced word packs a 16-bit value into a 32-bit register: the upper half carries each bit directly, and the lower half carries the same bit inverted. Balanced AND and balanced OR compute on such pairs so that the result is again a direct/complement pair. Each result bit therefore always has one rail high and one rail low, which keeps the switching count independent of the data. More complex functions are built from these two primitives in software by bitslicing: the register is treated as sixteen parallel one-bit copies of an algorithm.

Every balanced operation takes two cycles. In the first cycle the result register is forced to all zeros, a precharge step. In the second cycle the balanced result is written into the register and marked valid. Plain AND and OR on unencoded data are also supported. They complete in one cycle, so the same unit serves as an ordinary bitwise ALU for non-sensitive code. An encoding-error flag goes with each balanced result and reports operands whose rails are not true complements.

Top module: `dual_rail_alu`

## Requirements
- R1: While reset is asserted and in the first cycle after it, resData is zero and resValid and encErr are low.
- R2: The opcode is 2 bits: 00 is plain AND and 01 is plain OR on all 32 bits. A plain request sampled at a rising edge shows its result, with resValid high and encErr low, right after that edge.
- R3: Opcode 10 is balanced AND. Its result upper half is (A[31:16] & B[31:16]) and its lower half is (A[15:0] | B[15:0]).
- R4: Opcode 11 is balanced OR. Its result upper half is (A[31:16] | B[31:16]) and its lower half is (A[15:0] & B[15:0]).
- R5: After the edge that accepts a balanced request, resData is all zeros with resValid low (precharge). After the following edge, the balanced result appears with resValid high.
- R6: resValid is high for exactly one cycle per accepted request. In cycles with no completion it is low and resData keeps its last value.
- R7: A request presented while a balanced operation is in its precharge cycle is ignored. It produces no result and does not change the pending balanced result.
- R8: With a balanced result, encErr is high exactly when either operand has a bit position i (0..15) where bit 16+i equals bit i. encErr is low for plain operations and whenever resValid is low.
- R9: A balanced operation on two well-formed operands gives a well-formed result: resData[31:16] equals ~resData[15:0].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Request strobe, sampled at the rising edge |
| inOp | input | 2 | Opcode: 00 AND, 01 OR, 10 balanced AND, 11 balanced OR |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| resData | output | 32 | Registered result |
| resValid | output | 1 | High in the cycle a result is presented |
| encErr | output | 1 | Operand encoding error, reported with a balanced result |

## Verification
Balanced operations are run on all-zero and all-one values, on alternating-bit values and on pseudo-random well-formed pairs. These show whether each rail uses the right gate: a swapped gate on either half shows up on the alternating patterns. Plain operations are run on unencoded data to separate them from the balanced path. Requests are issued back to back and during the precharge cycle, which shows whether the two-cycle sequence is kept and whether late requests are dropped. Operands with a single broken bit pair on either side, and sometimes on both, exercise the error flag.

// File: rtl/dual_rail_pkg.sv
package dual_rail_pkg;

  typedef enum logic [1:0] {
    OP_PLAIN_AND = 2'b00,
    OP_PLAIN_OR  = 2'b01,
    OP_BAL_AND   = 2'b10,
    OP_BAL_OR    = 2'b11
  } railOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;    // latch operands of a balanced request
    logic precharge;  // clear result register
    logic plainWr;    // write plain result
    logic balWr;      // write balanced result
  } railStrb_t;

endpackage

// File: rtl/rail_ctrl.sv
module rail_ctrl
  import dual_rail_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  input  logic      isBal,
  output railStrb_t strb
);

  typedef enum logic {ST_IDLE, ST_EVAL} ctrlSt_e;
  ctrlSt_e state, stateNxt;

  always_comb begin
    strb     = '0;
    stateNxt = state;
    unique case (state)
      ST_IDLE: begin
        if (inValid && isBal) begin
          strb.capture   = 1'b1;
          strb.precharge = 1'b1;
          stateNxt       = ST_EVAL;
        end else if (inValid) begin
          strb.plainWr   = 1'b1;
        end
      end
      ST_EVAL: begin
        strb.balWr = 1'b1;
        stateNxt   = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  // R5
  prech_then_eval_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.precharge |=> strb.balWr);

endmodule

// File: rtl/rail_datapath.sv
module rail_datapath
  import dual_rail_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  railStrb_t             strb,
  input  logic                  selOr,
  input  logic [2*HALF_W-1:0]   opA,
  input  logic [2*HALF_W-1:0]   opB,
  output logic [2*HALF_W-1:0]   resData,
  output logic                  resValid,
  output logic                  encErr
);

  localparam int WORD_W = 2 * HALF_W;

  logic [WORD_W-1:0] holdA, holdB;
  logic              holdOr;
  logic [HALF_W-1:0] dirRes, cmpRes, badA, badB;
  logic [WORD_W-1:0] plainRes;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdA  <= '0;
      holdB  <= '0;
      holdOr <= 1'b0;
    end else if (strb.capture) begin
      holdA  <= opA;
      holdB  <= opB;
      holdOr <= selOr;
    end
  end

  // one complementary gate pair per bit slice
  for (genvar i = 0; i < HALF_W; i++) begin : g_slice
    logic dA, dB, cA, cB;
    assign dA = holdA[HALF_W+i];
    assign dB = holdB[HALF_W+i];
    assign cA = holdA[i];
    assign cB = holdB[i];
    assign dirRes[i] = holdOr ? (dA | dB) : (dA & dB);
    assign cmpRes[i] = holdOr ? (cA & cB) : (cA | cB);
    assign badA[i]   = ~(dA ^ cA);
    assign badB[i]   = ~(dB ^ cB);
  end

  assign plainRes = selOr ? (opA | opB) : (opA & opB);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resData  <= '0;
      resValid <= 1'b0;
      encErr   <= 1'b0;
    end else begin
      resValid <= strb.plainWr | strb.balWr;
      encErr   <= 1'b0;
      if (strb.precharge) begin
        resData <= '0;
      end else if (strb.plainWr) begin
        resData <= plainRes;
      end else if (strb.balWr) begin
        resData <= {dirRes, cmpRes};
        encErr  <= |(badA | badB);
      end
    end
  end

  // R5
  prech_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.precharge |=> (resData == '0) && !resValid);

  // R9
  rail_compl_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.balWr && !(|(badA | badB))) |=>
      (resData[WORD_W-1:HALF_W] == ~resData[HALF_W-1:0]));

  // R7
  hold_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.balWr |=> $stable(holdA) && $stable(holdB) && $stable(holdOr));

  // R8
  err_with_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    encErr |-> resValid);

endmodule

// File: rtl/dual_rail_alu.sv
module dual_rail_alu
  import dual_rail_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic [1:0]          inOp,
  input  logic [2*HALF_W-1:0] opA,
  input  logic [2*HALF_W-1:0] opB,
  output logic [2*HALF_W-1:0] resData,
  output logic                resValid,
  output logic                encErr
);

  railStrb_t strb;

  rail_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .isBal   (inOp[1]),
    .strb    (strb)
  );

  rail_datapath #(.HALF_W(HALF_W)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .selOr    (inOp[0]),
    .opA      (opA),
    .opB      (opB),
    .resData  (resData),
    .resValid (resValid),
    .encErr   (encErr)
  );

endmodule

// File: tb/test_dual_rail_alu.sv
module test_dual_rail_alu;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [1:0]  inOp = 2'b00;
  logic [31:0] opA = '0, opB = '0;
  logic [31:0] resData;
  logic        resValid, encErr;

  int vecCnt = 0;
  int missCnt = 0;
  int cycCnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_rail_alu i_dual_rail_alu (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inOp(inOp),
    .opA(opA), .opB(opB), .resData(resData), .resValid(resValid), .encErr(encErr)
  );

  // reference model state
  logic [31:0] pendQ[$];
  bit          pendErrQ[$];
  bit          mBusy = 0;
  logic [31:0] mLast = '0;
  logic [31:0] expData;
  bit          expValid, expErr;
  string       expTag;
  int unsigned seed = 32'h1234_abcd;

  function automatic logic [31:0] mkBal(input logic [15:0] x);
    return {x, ~x};
  endfunction

  function automatic int unsigned nextRnd(input int unsigned s);
    int unsigned t = s;
    t = t ^ (t << 13);
    t = t ^ (t >> 17);
    t = t ^ (t << 5);
    return t;
  endfunction

  // behavioural step: expectation after the coming rising edge
  task automatic modelStep(input bit v, input logic [1:0] op,
                           input logic [31:0] a, input logic [31:0] b);
    if (mBusy) begin
      expData  = pendQ.pop_front();
      expErr   = pendErrQ.pop_front();
      expValid = 1;
      mBusy    = 0;
      expTag   = v ? "R7" : (op[0] ? "R4" : "R3");
      if (expErr) expTag = {expTag, "/R8"};
      else        expTag = {expTag, "/R9"};
    end else if (v && op[1]) begin
      logic [31:0] r;
      bit bad = 0;
      for (int i = 0; i < 16; i++) begin
        if (op[0]) begin
          r[16+i] = a[16+i] | b[16+i];
          r[i]    = a[i] & b[i];
        end else begin
          r[16+i] = a[16+i] & b[16+i];
          r[i]    = a[i] | b[i];
        end
        if (a[16+i] == a[i] || b[16+i] == b[i]) bad = 1;
      end
      pendQ.push_back(r);
      pendErrQ.push_back(bad);
      mBusy = 1;
      expData = '0; expValid = 0; expErr = 0;
      expTag = "R5";
    end else if (v) begin
      expData = op[0] ? (a | b) : (a & b);
      expValid = 1; expErr = 0;
      expTag = "R2";
    end else begin
      expData = mLast; expValid = 0; expErr = 0;
      expTag = "R6";
    end
    mLast = expData;
  endtask

  task automatic compareOut(input string tag);
    vecCnt++;
    if (resData !== expData || resValid !== expValid || encErr !== expErr) begin
      missCnt++;
      $display("FAIL %s: data=%h valid=%b err=%b expected data=%h valid=%b err=%b",
               tag, resData, resValid, encErr, expData, expValid, expErr);
    end
  endtask

  task automatic step(input bit v, input logic [1:0] op,
                      input logic [31:0] a, input logic [31:0] b);
    inValid = v; inOp = op; opA = a; opB = b;
    modelStep(v, op, a, b);
    @(posedge clk);
    #(CLK_PERIOD/4);
    compareOut(expTag);
  endtask

  task automatic idle();
    step(0, 2'b00, 32'hdead_beef, 32'h0bad_f00d);
  endtask

  // balanced op followed by its evaluate cycle
  task automatic balOp(input bit isOr, input logic [31:0] a, input logic [31:0] b);
    step(1, {1'b1, isOr}, a, b);
    idle();
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycCnt++;
      if (cycCnt > 20000) begin
        missCnt++;
        $display("FAIL watchdog R6: cycles=%0d expected completion", cycCnt);
        $display("== %0d vectors applied, %0d miscompares ==", vecCnt, missCnt);
        $finish;
      end
    end
  end

  initial begin : stim
    // R1: outputs zero during reset
    expData = '0; expValid = 0; expErr = 0;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      compareOut("R1");
    end
    rstN = 1'b1;
    inValid = 0;
    modelStep(0, 2'b00, '0, '0);
    @(posedge clk);
    #(CLK_PERIOD/4);
    compareOut("R1");

    // R2: plain ops on unencoded data, back to back
    step(1, 2'b00, 32'hf0f0_1234, 32'hff00_ff0f);
    step(1, 2'b01, 32'h0000_1234, 32'h8000_0001);
    step(1, 2'b00, 32'hffff_ffff, 32'h5555_aaaa);
    idle();
    idle();

    // R3 / R4 on boundary and alternating patterns
    balOp(0, mkBal(16'h0000), mkBal(16'hffff));
    balOp(0, mkBal(16'hffff), mkBal(16'hffff));
    balOp(0, mkBal(16'ha5a5), mkBal(16'h5a5a));
    balOp(0, mkBal(16'hc3c3), mkBal(16'hf00f));
    balOp(1, mkBal(16'h0000), mkBal(16'h0000));
    balOp(1, mkBal(16'ha5a5), mkBal(16'h5a5a));
    balOp(1, mkBal(16'h1234), mkBal(16'h8001));
    idle();

    // R7: request during precharge is dropped
    step(1, 2'b10, mkBal(16'h00ff), mkBal(16'h0f0f));
    step(1, 2'b01, 32'hffff_ffff, 32'hffff_ffff);
    idle();
    step(1, 2'b11, mkBal(16'h00ff), mkBal(16'h0f0f));
    step(1, 2'b10, mkBal(16'hffff), mkBal(16'hffff));
    // back-to-back balanced right after evaluate
    step(1, 2'b11, mkBal(16'h3333), mkBal(16'h4444));
    step(0, 2'b00, '0, '0);
    step(1, 2'b00, 32'h1111_2222, 32'h3333_ffff);

    // R8: broken bit pair on either operand
    balOp(0, mkBal(16'h1234) ^ 32'h0001_0000, mkBal(16'h00ff));
    balOp(1, mkBal(16'h1234), mkBal(16'h00ff) ^ 32'h0000_8000);
    balOp(0, 32'h0000_0000, 32'hffff_ffff);
    balOp(1, mkBal(16'hbeef), mkBal(16'hcafe));
    idle();

    // pseudo-random balanced and plain mix
    for (int k = 0; k < 200; k++) begin
      logic [15:0] x, y;
      int unsigned sel;
      seed = nextRnd(seed); x = seed[15:0]; sel = seed[31:28];
      seed = nextRnd(seed); y = seed[15:0];
      if (sel < 10) balOp(sel[0], mkBal(x), mkBal(y));
      else if (sel < 14) step(1, {1'b0, sel[0]}, {x, y}, {y, x});
      else idle();
    end
    idle();

    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, missCnt);
    $finish;
  end

endmodule